// File: doc/BRIEF.md
# Broadcast Line Packet Store with Byte-Serial Reader

This block buffers data captured from individual video lines so that a host can collect it later, one byte at a time, through a single 8-bit read port. An upstream capture stage hands over one line per packet as a burst of bytes. The first two bytes of a packet describe where the line came from (line number, field) and what kind of data it carries. The rest is the payload, for example a two-byte teletext addressing group followed by forty data bytes. The block does not interpret any of these bytes. Every line occupies exactly one fixed-size row of storage.

Storage is a byte RAM. Its first row-sized region is kept free for control use, and the remainder is cut into equal packet rows that are filled in a circular order. A counter tracks how many complete rows are waiting for the reader. The reader keeps a row/offset address that steps forward by one on each read. The host can also move that address with three commands: back to the first row, back to the start of the current row, or on to the start of the next row. When every row is occupied, new lines are discarded and a sticky flag records the loss.

Top module: `vbi_pktbuf`

## Requirements
- R1: After reset, pkt_count is 0, overflow is 0 and rd_data is 0x00.
- R2: Packet row r (0-based) occupies RAM addresses RSV_BYTES + r*ROW_BYTES up to the end of that row. With the defaults (2048-byte RAM, 44-byte rows, 44 reserved bytes) there are 45 rows. The k-th byte of a stored line, the two header bytes included, is read back unchanged as byte k of its row.
- R3: A line is a byte accepted with in_sop=1 followed by ROW_BYTES-1 bytes accepted with in_sop=0. pkt_count rises by one on the clock edge that accepts the last byte of the line, and is visible right after that edge. pkt_count never exceeds the row count.
- R4: A rd_req while pkt_count>0 puts the byte at the read address on rd_data after the next clock edge and advances the offset by one. Reading the last byte of a row moves the address to offset 0 of the following row and lowers pkt_count by one.
- R5: A rd_req while pkt_count is 0 gives rd_data = 0x00 and leaves the read address unchanged.
- R6: cmd_top sets the read address to row 0, offset 0, and loads pkt_count with the index of the row being written next, plus one if a line completes in the same cycle.
- R7: cmd_cur sets the read offset to 0 and keeps the row and pkt_count.
- R8: cmd_next, when pkt_count>0, moves the read address to offset 0 of the next row and lowers pkt_count by one. When pkt_count is 0 it has no effect.
- R9: After the last row, both the write row and the read row wrap to row 0.
- R10: A byte with in_sop=1 arriving while pkt_count equals the row count drops that whole line and sets overflow. The stored data and pkt_count are not changed. overflow stays at 1 until reset.
- R11: A byte with in_sop=1 in the middle of a line restarts the current row at offset 0. A byte with in_sop=0 that does not belong to an open line is ignored.
- R12: When several read-side inputs are high in one cycle, only the highest-priority one acts. The order is cmd_top, then cmd_cur, then cmd_next, then rd_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A captured byte is presented this cycle |
| in_sop | input | 1 | The presented byte is the first header byte of a line |
| in_byte | input | 8 | Captured byte |
| rd_req | input | 1 | Host reads one byte from the data port |
| cmd_top | input | 1 | Move the read address to the first packet row |
| cmd_cur | input | 1 | Move the read address to the start of the current row |
| cmd_next | input | 1 | Move the read address to the start of the next row |
| rd_data | output | 8 | Byte returned for the latest accepted read |
| pkt_count | output | 6 | Complete rows not yet passed by the reader |
| overflow | output | 1 | Sticky flag: a line was dropped because all rows were full |

## Verification
Every result appears right after the clock edge that samples its cause. The returned byte, the changed read address, the pkt_count change and the overflow flag each take effect on that edge, including the edge that accepts the last byte of a line. The bench drives inputs on the falling edge and compares all outputs 1 ns after the following rising edge, against a bench model updated from the state before that edge. The effect of a read-side command is confirmed by the data that later reads return, so the reader position is seen only at the ports.

// File: rtl/vbi_pkt_pkg.sv
package vbi_pkt_pkg;

  // Number of whole rows that fit after the reserved region.
  function automatic int rows_fit(int mem_bytes, int rsv_bytes, int row_bytes);
    return (mem_bytes - rsv_bytes) / row_bytes;
  endfunction

  // Byte address of offset off inside packet row row.
  function automatic int row_addr(int rsv_bytes, int row_bytes, int row, int off);
    return rsv_bytes + row * row_bytes + off;
  endfunction

  // Circular successor of a row index.
  function automatic int row_succ(int row, int num_rows);
    return (row == num_rows - 1) ? 0 : row + 1;
  endfunction

endpackage

// File: rtl/vbi_ram.sv
module vbi_ram #(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vbi_wr_ctrl.sv
module vbi_wr_ctrl
  import vbi_pkt_pkg::*;
#(
  parameter int ROW_BYTES = 44,
  parameter int RSV_BYTES = 44,
  parameter int NUM_ROWS  = 45,
  parameter int ADDR_W    = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sop,
  input  logic [7:0]                  in_byte,
  input  logic                        full,
  output logic                        we,
  output logic [ADDR_W-1:0]           waddr,
  output logic [7:0]                  wdata,
  output logic                        commit,
  output logic                        drop,
  output logic [$clog2(NUM_ROWS)-1:0] wr_row
);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int OFF_W = $clog2(ROW_BYTES);

  logic [OFF_W-1:0] idx_q;
  logic             open_q;
  logic [OFF_W-1:0] off;
  logic             take_sop;

  assign take_sop = in_valid & in_sop & ~full;
  assign drop     = in_valid & in_sop & full;
  assign we       = take_sop | (in_valid & ~in_sop & open_q);
  assign off      = in_sop ? '0 : idx_q;
  assign commit   = we & (off == OFF_W'(ROW_BYTES - 1));
  assign waddr    = ADDR_W'(row_addr(RSV_BYTES, ROW_BYTES, int'(wr_row), int'(off)));
  assign wdata    = in_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      open_q <= 1'b0;
      wr_row <= '0;
    end else if (commit) begin
      idx_q  <= '0;
      open_q <= 1'b0;
      wr_row <= ROW_W'(row_succ(int'(wr_row), NUM_ROWS));
    end else if (we) begin
      idx_q  <= off + OFF_W'(1);
      open_q <= 1'b1;
    end else if (drop) begin
      idx_q  <= '0;
      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vbi_rd_ctrl.sv
module vbi_rd_ctrl
  import vbi_pkt_pkg::*;
#(
  parameter int ROW_BYTES = 44,
  parameter int RSV_BYTES = 44,
  parameter int NUM_ROWS  = 45,
  parameter int ADDR_W    = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_req,
  input  logic                         cmd_top,
  input  logic                         cmd_cur,
  input  logic                         cmd_next,
  input  logic                         avail,
  output logic                         re,
  output logic                         zero_rd,
  output logic [ADDR_W-1:0]            raddr,
  output logic                         dec,
  output logic [$clog2(NUM_ROWS)-1:0]  rd_row,
  output logic [$clog2(ROW_BYTES)-1:0] rd_off
);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int OFF_W = $clog2(ROW_BYTES);

  logic cur_go, nxt_go, rd_go, last;

  assign cur_go  = cmd_cur & ~cmd_top;
  assign nxt_go  = cmd_next & ~cmd_top & ~cmd_cur;
  assign rd_go   = rd_req & ~cmd_top & ~cmd_cur & ~cmd_next;
  assign re      = rd_go & avail;
  assign zero_rd = rd_go & ~avail;
  assign last    = (rd_off == OFF_W'(ROW_BYTES - 1));
  assign dec     = (nxt_go & avail) | (re & last);
  assign raddr   = ADDR_W'(row_addr(RSV_BYTES, ROW_BYTES, int'(rd_row), int'(rd_off)));

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_top) begin
      rd_row <= '0;
      rd_off <= '0;
    end else if (cur_go) begin
      rd_off <= '0;
    end else if ((nxt_go & avail) || (re & last)) begin
      rd_row <= ROW_W'(row_succ(int'(rd_row), NUM_ROWS));
      rd_off <= '0;
    end else if (re) begin
      rd_off <= rd_off + OFF_W'(1);
    end
  end
endmodule

// File: rtl/vbi_pkt_cnt.sv
module vbi_pkt_cnt #(
  parameter int NUM_ROWS = 45,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             dec,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             drop,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             overflow
);
  assign full = (count == CNT_W'(NUM_ROWS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (load) count <= load_val + CNT_W'(commit);
      else      count <= count + CNT_W'(commit) - CNT_W'(dec);
      if (drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/vbi_pktbuf.sv
module vbi_pktbuf
  import vbi_pkt_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int ROW_BYTES = 44,
  parameter int RSV_BYTES = 44,
  localparam int NUM_ROWS = rows_fit(MEM_BYTES, RSV_BYTES, ROW_BYTES),
  localparam int CNT_W    = $clog2(NUM_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_byte,
  input  logic             rd_req,
  input  logic             cmd_top,
  input  logic             cmd_cur,
  input  logic             cmd_next,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] pkt_count,
  output logic             overflow
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int ROW_W  = $clog2(NUM_ROWS);
  localparam int OFF_W  = $clog2(ROW_BYTES);

  // Events between the pieces, named for the checker.
  logic              we, commit, drop, full;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [7:0]        wdata, ram_q;
  logic [ROW_W-1:0]  wr_row, rd_row;
  logic [OFF_W-1:0]  rd_off;
  logic              re, zero_rd, dec;
  logic              zero_q;

  vbi_wr_ctrl #(.ROW_BYTES(ROW_BYTES), .RSV_BYTES(RSV_BYTES),
                .NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_byte(in_byte), .full(full), .we(we), .waddr(waddr), .wdata(wdata),
    .commit(commit), .drop(drop), .wr_row(wr_row));

  vbi_rd_ctrl #(.ROW_BYTES(ROW_BYTES), .RSV_BYTES(RSV_BYTES),
                .NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .cmd_top(cmd_top),
    .cmd_cur(cmd_cur), .cmd_next(cmd_next), .avail(pkt_count != '0),
    .re(re), .zero_rd(zero_rd), .raddr(raddr), .dec(dec),
    .rd_row(rd_row), .rd_off(rd_off));

  vbi_pkt_cnt #(.NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .commit(commit), .dec(dec), .load(cmd_top),
    .load_val(CNT_W'(wr_row)), .drop(drop), .count(pkt_count),
    .full(full), .overflow(overflow));

  vbi_ram #(.DEPTH(MEM_BYTES), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(ram_q));

  // A read with nothing waiting returns zero instead of RAM data.
  always_ff @(posedge clk) begin
    if (!rst_n)              zero_q <= 1'b1;
    else if (re || zero_rd)  zero_q <= zero_rd;
  end

  assign rd_data = zero_q ? 8'h00 : ram_q;
endmodule

// File: rtl/vbi_pktbuf_chk.sv
module vbi_pktbuf_chk #(
  parameter int NUM_ROWS = 45,
  parameter int CNT_W    = 6,
  parameter int ROW_W    = 6,
  parameter int OFF_W    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sop,
  input logic             rd_req,
  input logic             cmd_top,
  input logic             cmd_cur,
  input logic             cmd_next,
  input logic [7:0]       rd_data,
  input logic [CNT_W-1:0] pkt_count,
  input logic             overflow,
  input logic [ROW_W-1:0] wr_row,
  input logic [ROW_W-1:0] rd_row,
  input logic [OFF_W-1:0] rd_off
);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pkt_count) <= NUM_ROWS);

  p_idle_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == '0) |-> (rd_off == '0));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cmd_top && !cmd_cur && !cmd_next && pkt_count == '0)
    |=> (rd_data == 8'h00 && $stable(rd_row) && $stable(rd_off)));

  p_top_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_top |=> (rd_row == '0 && rd_off == '0));

  p_cur_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cur && !cmd_top) |=> (rd_off == '0 && $stable(rd_row)));

  p_ring_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(rd_row) + int'(pkt_count)) % NUM_ROWS) == int'(wr_row));

  p_drop_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && int'(pkt_count) == NUM_ROWS) |=> overflow);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind vbi_pktbuf vbi_pktbuf_chk #(.NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W),
                                 .ROW_W(ROW_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
  .rd_req(rd_req), .cmd_top(cmd_top), .cmd_cur(cmd_cur), .cmd_next(cmd_next),
  .rd_data(rd_data), .pkt_count(pkt_count), .overflow(overflow),
  .wr_row(wr_row), .rd_row(rd_row), .rd_off(rd_off));

// File: tb/tb_vbi_pktbuf.sv
module tb_vbi_pktbuf;
  localparam int NR = 45;
  localparam int RB = 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, rd_req = 0, cmd_top = 0, cmd_cur = 0, cmd_next = 0;
  logic [7:0] in_byte = '0;
  logic [7:0] rd_data;
  logic [5:0] pkt_count;
  logic overflow;

  always #4 clk = ~clk;

  vbi_pktbuf dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_byte(in_byte), .rd_req(rd_req), .cmd_top(cmd_top), .cmd_cur(cmd_cur),
    .cmd_next(cmd_next), .rd_data(rd_data), .pkt_count(pkt_count), .overflow(overflow));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string rd_tag = "R4";

  // Bench model of the buffer, built from the requirements.
  logic [7:0] mrow [NR][RB];
  int mcnt = 0, mrd = 0, moff = 0, mwr = 0, midx = 0;
  bit mopen = 0, movf = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int l, int k);
    return 8'((l * 37 + k * 5 + 3) & 255);
  endfunction

  task automatic cyc(bit v, bit s, logic [7:0] b, bit rr, bit ct, bit cc, bit cn);
    int pw, exp_rd;
    bit commit, avail, rd_go, dec;
    @(negedge clk);
    in_valid = v; in_sop = s; in_byte = b;
    rd_req = rr; cmd_top = ct; cmd_cur = cc; cmd_next = cn;
    @(posedge clk);
    pw = mwr; commit = 0; avail = (mcnt != 0); dec = 0; exp_rd = 0;
    if (v && s && mcnt == NR) begin
      movf = 1; mopen = 0; midx = 0;
    end else if (v && (s || mopen)) begin
      if (s) midx = 0;
      mrow[mwr][midx] = b;
      if (midx == RB - 1) begin
        commit = 1; mopen = 0; midx = 0; mwr = (mwr + 1) % NR;
      end else begin
        midx++; mopen = 1;
      end
    end
    rd_go = rr && !ct && !cc && !cn;
    if (ct) begin
      mrd = 0; moff = 0;
    end else if (cc) begin
      moff = 0;
    end else if (cn) begin
      if (avail) begin mrd = (mrd + 1) % NR; moff = 0; dec = 1; end
    end else if (rr) begin
      if (avail) begin
        exp_rd = mrow[mrd][moff];
        if (moff == RB - 1) begin moff = 0; mrd = (mrd + 1) % NR; dec = 1; end
        else moff++;
      end
    end
    mcnt = ct ? pw + int'(commit) : mcnt + int'(commit) - int'(dec);
    #1;
    chk("R3", pkt_count, mcnt);
    chk("R10", overflow, movf);
    if (rd_go) chk(avail ? rd_tag : "R5", rd_data, exp_rd);
  endtask

  task automatic wline(int l);
    for (int k = 0; k < RB; k++) cyc(1, k == 0, pat(l, k), 0, 0, 0, 0);
  endtask

  task automatic rd(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", pkt_count, 0); chk("R1", overflow, 0); chk("R1", rd_data, 0);

    rd(2);                                   // R5: empty reads give zero
    rd_tag = "R2"; wline(1);
    chk("R3", pkt_count, 1);
    for (int k = 0; k < 10; k++) cyc(1, k == 0, pat(2, k), 0, 0, 0, 0);
    wline(3);                                // R11: restart on mid-line sop
    for (int k = 0; k < 5; k++) cyc(1, 0, 8'hEE, 0, 0, 0, 0);   // R11: stray bytes
    chk("R11", pkt_count, 2);
    rd(RB);                                  // R2 row 0 verbatim
    rd_tag = "R11"; rd(RB);                  // row 1 holds line 3 only
    chk("R4", pkt_count, 0);

    rd_tag = "R4"; wline(4); wline(5);
    rd(6);
    rd_tag = "R7"; cyc(0, 0, 0, 0, 0, 1, 0); rd(3);
    rd_tag = "R8"; cyc(0, 0, 0, 0, 0, 0, 1); chk("R8", pkt_count, 1); rd(2);
    cyc(0, 0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 0, 1); chk("R8", pkt_count, 0);
    rd_tag = "R6"; cyc(0, 0, 0, 0, 1, 0, 0); chk("R6", pkt_count, 4); rd(3);
    rd_tag = "R12"; cyc(0, 0, 0, 1, 1, 0, 1); rd(2);
    cyc(0, 0, 0, 1, 0, 1, 1); rd(1);

    rd_tag = "R9";
    for (int l = 0; l < NR - 4; l++) wline(10 + l);
    chk("R10", pkt_count, NR);
    wline(99);                               // dropped
    chk("R10", overflow, 1); chk("R10", pkt_count, NR);
    rd(RB * NR);                             // crosses the wrap point
    chk("R9", pkt_count, 0);

    rd_tag = "R4";
    begin
      int l = 200, k = 0;
      for (int c = 0; c < 6000; c++) begin
        bit v, s, rr, ct, cc, cn;
        v = ($urandom % 3) != 0;
        s = v && (k == 0 || ($urandom % 300) == 0);
        if (s) k = 0;
        rr = ($urandom % 2) == 0;
        ct = ($urandom % 400) == 0;
        cc = ($urandom % 150) == 0;
        cn = ($urandom % 90) == 0;
        cyc(v, s, pat(l, k), rr, ct, cc, cn);
        if (v) begin
          k++;
          if (k == RB) begin k = 0; l++; end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule